// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Unit

This unit sits beside a processor core and watches two streams. The first is the program counter, qualified by a valid strobe. The second is the operand access, made of an address, a data word and a valid strobe. Both streams carry the current address-space identifier (ASID). When a programmed condition matches, the unit raises `trig_o` for one cycle. It offers four program-counter comparators, two inclusive address-range comparators and one data comparator with a per-bit ignore mask. Any program-counter or range comparator can also be made to require an ASID match.

Two ports can write the breakpoint registers. One belongs to an external debug host and the other to the processor's privileged debug-write path. Only the host can read. A lock bit, which only the host can set, makes the unit drop every write from the processor. A mode bit picks one of two firing schemes. In single-level mode, any enabled hit fires. In double-level mode, a program-counter hit arms the unit, and a later operand hit fires it.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: After a synchronous active-low reset, `trig_o` is 0, every register holds 0, and a host read of index 0 returns 0.
- R2: Program-counter comparator k (k = 0..3, value register at index 4+k) hits when `pc_valid` is 1, its enable bit is set and `pc_addr` equals the value. The resulting `trig_o` pulse appears one clock after the inputs are sampled.
- R3: Range set j (j = 0..1, low bound at index 8+2j, high bound at index 9+2j) hits when its enable bit is set and low ≤ `op_addr` ≤ high, with both bounds inclusive.
- R4: No operand comparator (range or data) hits in a cycle where `op_valid` is 0.
- R5: The data comparator (value at index 12, mask at index 13) hits when it is enabled and `op_data` equals the value in every bit whose mask bit is 0. Bits whose mask bit is 1 are ignored.
- R6: When a comparator's ASID-qualify bit is set, that comparator also needs `cur_asid` to equal the programmed identifier. Program-counter comparators use index 14 and range sets use index 15.
- R7: In single-level mode (index 0 bit 8 = 0), any enabled hit fires. In double-level mode, a program-counter hit only arms the unit, and a later operand hit fires it and disarms it. Each firing yields a single-cycle pulse.
- R8: Index 0 bit 4 is the processor lock, and only the host can change it. While it is 1, every processor-port write is discarded with no effect on any register.
- R9: When both ports write in the same cycle, only the host write takes effect.
- R10: A host read of index 0 returns bit 8 = mode, bit 4 = lock, bit 1 = fired and bit 0 = level-one hit, with all other bits 0. The read data appears one clock after `hst_rd`. The read clears both status bits, but a firing in the same cycle still sets its bit.
- R11: Any accepted write to index 0 or index 1 clears the armed state.
- R12: Index 1 holds the enables and qualifiers: bits 3:0 are the program-counter enables, bits 5:4 the range enables, bit 6 the data enable, bits 11:8 the program-counter ASID qualifiers and bits 13:12 the range ASID qualifiers. A host read returns any register, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_we | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_idx | input | 5 | Host register index |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid one cycle after `hst_rd` |
| cpu_we | input | 1 | Processor debug-write strobe |
| cpu_idx | input | 5 | Processor register index |
| cpu_wdata | input | 32 | Processor write data |
| pc_valid | input | 1 | Program counter valid |
| pc_addr | input | ADDR_W | Program counter |
| op_valid | input | 1 | Operand access valid |
| op_addr | input | ADDR_W | Operand address |
| op_data | input | DATA_W | Operand data |
| cur_asid | input | ASID_W | Current address-space identifier |
| trig_o | output | 1 | Debug trigger pulse |

## Verification
Register writes take effect at the clock edge that samples them. The comparators are purely combinational, so a hit presented at an edge shows on `trig_o` just after that edge. Read data is also registered once, so `hst_rdata` is due one clock after `hst_rd`. The driver tags every expected item with the cycle number one past the edge that samples its stimulus. The monitor pops and compares only items whose tag matches the current cycle, and it samples on the falling edge, half a period after the result appears.

// File: rtl/bkpt_pkg.sv
// Shared constants for the breakpoint trigger unit: register index map,
// field positions in the status and enable registers, comparator counts.
// Assumes register bus width REG_W holds every stored field.
package bkpt_pkg;

    localparam int REG_W   = 32;
    localparam int IDX_W   = 5;
    localparam int NUM_PC  = 4;
    localparam int NUM_RNG = 2;

    // register indices
    localparam logic [IDX_W-1:0] IX_CSR   = 5'd0;
    localparam logic [IDX_W-1:0] IX_CTRL  = 5'd1;
    localparam logic [IDX_W-1:0] IX_PC0   = 5'd4;
    localparam logic [IDX_W-1:0] IX_RNG0  = 5'd8;
    localparam logic [IDX_W-1:0] IX_DVAL  = 5'd12;
    localparam logic [IDX_W-1:0] IX_DMSK  = 5'd13;
    localparam logic [IDX_W-1:0] IX_PASID = 5'd14;
    localparam logic [IDX_W-1:0] IX_OASID = 5'd15;

    // status register bit positions
    localparam int CSR_L1   = 0;
    localparam int CSR_FIRE = 1;
    localparam int CSR_LOCK = 4;
    localparam int CSR_TWO  = 8;

    // enable register field positions
    localparam int PC_EN_LSB  = 0;
    localparam int RNG_EN_LSB = PC_EN_LSB + NUM_PC;
    localparam int DAT_EN_BIT = RNG_EN_LSB + NUM_RNG;
    localparam int PC_AQ_LSB  = 8;
    localparam int RNG_AQ_LSB = PC_AQ_LSB + NUM_PC;
    localparam int CTRL_W     = RNG_AQ_LSB + NUM_RNG;

endpackage

// File: rtl/bkpt_regs.sv
// Register file with two write ports and one host read port.
// Host writes always win; processor writes are dropped while the lock
// bit is set. Status bits are set by the sequencer and cleared by a host
// read of index 0. Assumes ADDR_W and DATA_W do not exceed REG_W.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ASID_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           hst_we,
    input  logic                           hst_rd,
    input  logic [IDX_W-1:0]               hst_idx,
    input  logic [REG_W-1:0]               hst_wdata,
    output logic [REG_W-1:0]               hst_rdata,
    input  logic                           cpu_we,
    input  logic [IDX_W-1:0]               cpu_idx,
    input  logic [REG_W-1:0]               cpu_wdata,
    input  logic                           set_l1,
    input  logic                           set_fire,
    output logic [NUM_PC-1:0][ADDR_W-1:0]  pc_bp,
    output logic [NUM_RNG-1:0][ADDR_W-1:0] rng_lo,
    output logic [NUM_RNG-1:0][ADDR_W-1:0] rng_hi,
    output logic [DATA_W-1:0]              dval,
    output logic [DATA_W-1:0]              dmsk,
    output logic [ASID_W-1:0]              pc_asid,
    output logic [ASID_W-1:0]              op_asid,
    output logic [NUM_PC-1:0]              pc_en,
    output logic [NUM_RNG-1:0]             rng_en,
    output logic                           dat_en,
    output logic [NUM_PC-1:0]              pc_aq,
    output logic [NUM_RNG-1:0]             rng_aq,
    output logic                           two_level,
    output logic                           cfg_wr
);

    logic              lock_q;
    logic              two_q;
    logic [1:0]        st_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              wr_go;
    logic [IDX_W-1:0]  wr_idx;
    logic [REG_W-1:0]  wr_dat;
    logic              rd_csr;
    logic [REG_W-1:0]  rd_mux;

    // Arbitrate the two write ports: host first, processor only when unlocked.
    always_comb begin
        wr_go  = hst_we | (cpu_we & ~lock_q);
        wr_idx = hst_we ? hst_idx   : cpu_idx;
        wr_dat = hst_we ? hst_wdata : cpu_wdata;
    end

    assign rd_csr = hst_rd && (hst_idx == IX_CSR);
    assign cfg_wr = wr_go && ((wr_idx == IX_CSR) || (wr_idx == IX_CTRL));

    // Lock bit: only the host port may change it.
    always_ff @(posedge clk) begin
        if (!rst_n)                             lock_q <= 1'b0;
        else if (hst_we && hst_idx == IX_CSR)   lock_q <= hst_wdata[CSR_LOCK];
    end

    // Mode bit and enable register: written by whichever port wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            two_q  <= 1'b0;
            ctrl_q <= '0;
        end else if (wr_go) begin
            if (wr_idx == IX_CSR)  two_q  <= wr_dat[CSR_TWO];
            if (wr_idx == IX_CTRL) ctrl_q <= wr_dat[CTRL_W-1:0];
        end
    end

    // Status bits: cleared by a host read, set by firing events (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~{2{rd_csr}}) | {set_fire, set_l1};
    end

    // Program-counter comparator values, one register per comparator.
    for (genvar g = 0; g < NUM_PC; g++) begin : g_pc
        localparam logic [IDX_W-1:0] MY_IX = IDX_W'(int'(IX_PC0) + g);
        always_ff @(posedge clk) begin
            if (!rst_n)                          pc_bp[g] <= '0;
            else if (wr_go && wr_idx == MY_IX)   pc_bp[g] <= wr_dat[ADDR_W-1:0];
        end
    end

    // Range bounds, a low and a high register per set.
    for (genvar g = 0; g < NUM_RNG; g++) begin : g_rng
        localparam logic [IDX_W-1:0] LO_IX = IDX_W'(int'(IX_RNG0) + 2 * g);
        localparam logic [IDX_W-1:0] HI_IX = IDX_W'(int'(IX_RNG0) + 2 * g + 1);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rng_lo[g] <= '0;
                rng_hi[g] <= '0;
            end else if (wr_go) begin
                if (wr_idx == LO_IX) rng_lo[g] <= wr_dat[ADDR_W-1:0];
                if (wr_idx == HI_IX) rng_hi[g] <= wr_dat[ADDR_W-1:0];
            end
        end
    end

    // Data value, data mask and the two ASID values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dval    <= '0;
            dmsk    <= '0;
            pc_asid <= '0;
            op_asid <= '0;
        end else if (wr_go) begin
            if (wr_idx == IX_DVAL)  dval    <= wr_dat[DATA_W-1:0];
            if (wr_idx == IX_DMSK)  dmsk    <= wr_dat[DATA_W-1:0];
            if (wr_idx == IX_PASID) pc_asid <= wr_dat[ASID_W-1:0];
            if (wr_idx == IX_OASID) op_asid <= wr_dat[ASID_W-1:0];
        end
    end

    // Select the register addressed by the host for readback.
    always_comb begin
        rd_mux = '0;
        if (hst_idx == IX_CSR) begin
            rd_mux[CSR_TWO]  = two_q;
            rd_mux[CSR_LOCK] = lock_q;
            rd_mux[CSR_FIRE] = st_q[1];
            rd_mux[CSR_L1]   = st_q[0];
        end
        if (hst_idx == IX_CTRL)  rd_mux = REG_W'(ctrl_q);
        if (hst_idx == IX_DVAL)  rd_mux = REG_W'(dval);
        if (hst_idx == IX_DMSK)  rd_mux = REG_W'(dmsk);
        if (hst_idx == IX_PASID) rd_mux = REG_W'(pc_asid);
        if (hst_idx == IX_OASID) rd_mux = REG_W'(op_asid);
        for (int g = 0; g < NUM_PC; g++)
            if (hst_idx == IDX_W'(int'(IX_PC0) + g)) rd_mux = REG_W'(pc_bp[g]);
        for (int g = 0; g < NUM_RNG; g++) begin
            if (hst_idx == IDX_W'(int'(IX_RNG0) + 2 * g))     rd_mux = REG_W'(rng_lo[g]);
            if (hst_idx == IDX_W'(int'(IX_RNG0) + 2 * g + 1)) rd_mux = REG_W'(rng_hi[g]);
        end
    end

    // Register the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      hst_rdata <= '0;
        else if (hst_rd) hst_rdata <= rd_mux;
    end

    assign pc_en     = ctrl_q[PC_EN_LSB  +: NUM_PC];
    assign rng_en    = ctrl_q[RNG_EN_LSB +: NUM_RNG];
    assign dat_en    = ctrl_q[DAT_EN_BIT];
    assign pc_aq     = ctrl_q[PC_AQ_LSB  +: NUM_PC];
    assign rng_aq    = ctrl_q[RNG_AQ_LSB +: NUM_RNG];
    assign two_level = two_q;

    // R8: a processor write while locked changes no stored value.
    p_lock_blocks_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && cpu_we && !hst_we) |=>
            (pc_bp == $past(pc_bp)) && (dval == $past(dval)) && (ctrl_q == $past(ctrl_q)));

    // R8: the lock bit only moves on a host write to index 0.
    p_lock_host_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_we && hst_idx == IX_CSR) |=> $stable(lock_q));

    // R9: on a collision the host data lands.
    p_host_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_we && cpu_we && hst_idx == IX_DVAL) |=> (dval == $past(hst_wdata[DATA_W-1:0])));

    // R10: reading index 0 with no new event leaves the status clear.
    p_status_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_csr && !set_l1 && !set_fire) |=> (st_q == 2'b00));

endmodule

// File: rtl/bkpt_match.sv
// Combinational comparators: program-counter equality, inclusive address
// ranges and masked data equality, each optionally ASID-qualified.
// Outputs are a program-counter hit and an operand hit, both gated by
// their input valid strobes.
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ASID_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pc_valid,
    input  logic [ADDR_W-1:0]              pc_addr,
    input  logic                           op_valid,
    input  logic [ADDR_W-1:0]              op_addr,
    input  logic [DATA_W-1:0]              op_data,
    input  logic [ASID_W-1:0]              cur_asid,
    input  logic [NUM_PC-1:0][ADDR_W-1:0]  pc_bp,
    input  logic [NUM_RNG-1:0][ADDR_W-1:0] rng_lo,
    input  logic [NUM_RNG-1:0][ADDR_W-1:0] rng_hi,
    input  logic [DATA_W-1:0]              dval,
    input  logic [DATA_W-1:0]              dmsk,
    input  logic [ASID_W-1:0]              pc_asid,
    input  logic [ASID_W-1:0]              op_asid,
    input  logic [NUM_PC-1:0]              pc_en,
    input  logic [NUM_RNG-1:0]             rng_en,
    input  logic                           dat_en,
    input  logic [NUM_PC-1:0]              pc_aq,
    input  logic [NUM_RNG-1:0]             rng_aq,
    output logic                           pc_hit,
    output logic                           op_hit
);

    logic [NUM_PC-1:0]  pc_hits;
    logic [NUM_RNG-1:0] rng_hits;
    logic               dat_hit;
    logic               pc_asid_ok;
    logic               op_asid_ok;

    assign pc_asid_ok = (cur_asid == pc_asid);
    assign op_asid_ok = (cur_asid == op_asid);

    // One equality comparator per program-counter breakpoint.
    for (genvar g = 0; g < NUM_PC; g++) begin : g_pc
        assign pc_hits[g] = pc_valid && pc_en[g] && (pc_addr == pc_bp[g])
                            && (!pc_aq[g] || pc_asid_ok);
    end

    // One inclusive window comparator per range set.
    for (genvar g = 0; g < NUM_RNG; g++) begin : g_rng
        assign rng_hits[g] = op_valid && rng_en[g]
                             && (op_addr >= rng_lo[g]) && (op_addr <= rng_hi[g])
                             && (!rng_aq[g] || op_asid_ok);
    end

    // Masked data comparator: mask bit 1 removes that bit from the compare.
    assign dat_hit = op_valid && dat_en && (((op_data ^ dval) & ~dmsk) == '0);

    assign pc_hit = |pc_hits;
    assign op_hit = (|rng_hits) | dat_hit;

    // R2: no program-counter hit without its valid strobe.
    p_pc_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid |-> !pc_hit);

    // R4: no operand hit without its valid strobe.
    p_op_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !op_hit);

endmodule

// File: rtl/bkpt_seq.sv
// Level sequencer: turns comparator hits into a registered trigger pulse.
// Single-level fires on any hit; double-level arms on a program-counter
// hit and fires on a later operand hit. Configuration writes disarm.
module bkpt_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic two_level,
    input  logic cfg_wr,
    input  logic pc_hit,
    input  logic op_hit,
    output logic set_l1,
    output logic set_fire,
    output logic trig_o
);

    logic armed_q;
    logic fire;

    // Decide this cycle's firing and level-one event.
    always_comb begin
        if (two_level) begin
            fire   = armed_q && op_hit;
            set_l1 = pc_hit;
        end else begin
            fire   = pc_hit || op_hit;
            set_l1 = 1'b0;
        end
    end

    assign set_fire = fire;

    // Armed flag: set by a level-one hit, cleared by firing or reconfiguration.
    always_ff @(posedge clk) begin
        if (!rst_n)              armed_q <= 1'b0;
        else if (cfg_wr || fire) armed_q <= 1'b0;
        else if (set_l1)         armed_q <= 1'b1;
    end

    // Registered trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_o <= 1'b0;
        else        trig_o <= fire;
    end

    // R7: a firing always leaves the unit disarmed.
    p_disarm_after_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> !armed_q);

    // R7: in double-level mode the pulse lasts exactly one cycle.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && two_level) |=> !trig_o);

    // R11: a configuration write disarms.
    p_cfg_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !armed_q);

endmodule

// File: rtl/bkpt_trigger_unit.sv
// Top of the breakpoint trigger unit: register file, comparators and level
// sequencer. Assumes ADDR_W and DATA_W are at most 32 (the register bus).
module bkpt_trigger_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_we,
    input  logic              hst_rd,
    input  logic [4:0]        hst_idx,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    input  logic              cpu_we,
    input  logic [4:0]        cpu_idx,
    input  logic [31:0]       cpu_wdata,
    input  logic              pc_valid,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic              op_valid,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic [ASID_W-1:0] cur_asid,
    output logic              trig_o
);

    logic [NUM_PC-1:0][ADDR_W-1:0]  pc_bp;
    logic [NUM_RNG-1:0][ADDR_W-1:0] rng_lo;
    logic [NUM_RNG-1:0][ADDR_W-1:0] rng_hi;
    logic [DATA_W-1:0]              dval;
    logic [DATA_W-1:0]              dmsk;
    logic [ASID_W-1:0]              pc_asid;
    logic [ASID_W-1:0]              op_asid;
    logic [NUM_PC-1:0]              pc_en;
    logic [NUM_RNG-1:0]             rng_en;
    logic                           dat_en;
    logic [NUM_PC-1:0]              pc_aq;
    logic [NUM_RNG-1:0]             rng_aq;
    logic                           two_level;
    logic                           cfg_wr;
    logic                           pc_hit;
    logic                           op_hit;
    logic                           set_l1;
    logic                           set_fire;

    bkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .hst_we(hst_we), .hst_rd(hst_rd), .hst_idx(hst_idx),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata),
        .set_l1(set_l1), .set_fire(set_fire),
        .pc_bp(pc_bp), .rng_lo(rng_lo), .rng_hi(rng_hi),
        .dval(dval), .dmsk(dmsk), .pc_asid(pc_asid), .op_asid(op_asid),
        .pc_en(pc_en), .rng_en(rng_en), .dat_en(dat_en),
        .pc_aq(pc_aq), .rng_aq(rng_aq),
        .two_level(two_level), .cfg_wr(cfg_wr)
    );

    bkpt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .pc_valid(pc_valid), .pc_addr(pc_addr),
        .op_valid(op_valid), .op_addr(op_addr), .op_data(op_data),
        .cur_asid(cur_asid),
        .pc_bp(pc_bp), .rng_lo(rng_lo), .rng_hi(rng_hi),
        .dval(dval), .dmsk(dmsk), .pc_asid(pc_asid), .op_asid(op_asid),
        .pc_en(pc_en), .rng_en(rng_en), .dat_en(dat_en),
        .pc_aq(pc_aq), .rng_aq(rng_aq),
        .pc_hit(pc_hit), .op_hit(op_hit)
    );

    bkpt_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .two_level(two_level), .cfg_wr(cfg_wr),
        .pc_hit(pc_hit), .op_hit(op_hit),
        .set_l1(set_l1), .set_fire(set_fire), .trig_o(trig_o)
    );

endmodule

// File: tb/sim_bkpt_trigger_unit.sv
module sim_bkpt_trigger_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_we, hst_rd, cpu_we, pc_valid, op_valid;
    logic [4:0]  hst_idx, cpu_idx;
    logic [31:0] hst_wdata, cpu_wdata, hst_rdata;
    logic [31:0] pc_addr, op_addr, op_data;
    logic [7:0]  cur_asid;
    logic        trig_o;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    bkpt_trigger_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .hst_we(hst_we), .hst_rd(hst_rd), .hst_idx(hst_idx),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .cpu_we(cpu_we), .cpu_idx(cpu_idx), .cpu_wdata(cpu_wdata),
        .pc_valid(pc_valid), .pc_addr(pc_addr),
        .op_valid(op_valid), .op_addr(op_addr), .op_data(op_data),
        .cur_asid(cur_asid), .trig_o(trig_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pop every item due in this cycle and compare at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.is_rd) chk(hst_rdata, e.exp, e.tag);
            else         chk({31'b0, trig_o}, e.exp, e.tag);
        end
    end

    task automatic clr();
        hst_we = 0; hst_rd = 0; cpu_we = 0; pc_valid = 0; op_valid = 0;
        hst_idx = '0; cpu_idx = '0; hst_wdata = '0; cpu_wdata = '0;
        pc_addr = '0; op_addr = '0; op_data = '0; cur_asid = '0;
    endtask

    // Driver core: the current inputs are sampled at the next rising edge.
    task automatic step(input logic et, input string tag);
        sb.push_back('{cyc + 1, 1'b0, {31'b0, et}, tag});
        @(negedge clk);
        clr();
    endtask

    task automatic hw(input logic [4:0] i, input logic [31:0] d);
        hst_we = 1; hst_idx = i; hst_wdata = d;
        step(1'b0, "R12 write");
    endtask

    task automatic cw(input logic [4:0] i, input logic [31:0] d);
        cpu_we = 1; cpu_idx = i; cpu_wdata = d;
        step(1'b0, "R8 cpu write");
    endtask

    task automatic rd(input logic [4:0] i, input logic [31:0] e, input string tag);
        hst_rd = 1; hst_idx = i;
        sb.push_back('{cyc + 1, 1'b1, e, tag});
        step(1'b0, tag);
    endtask

    task automatic pcs(input logic [31:0] a, input logic [7:0] s, input logic et, input string tag);
        pc_valid = 1; pc_addr = a; cur_asid = s;
        step(et, tag);
    endtask

    task automatic ops(input logic v, input logic [31:0] a, input logic [31:0] d,
                       input logic [7:0] s, input logic et, input string tag);
        op_valid = v; op_addr = a; op_data = d; cur_asid = s;
        step(et, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        clr();
        repeat (3) @(negedge clk);
        chk({31'b0, trig_o}, 32'h0, "R1 trig in reset");
        rst_n = 1'b1;
        // R1: reset state
        rd(5'd0, 32'h0, "R1 csr after reset");
        rd(5'd4, 32'h0, "R1 pc0 after reset");

        // R2: single-level program-counter match
        hw(5'd4, 32'h1000);
        hw(5'd1, 32'h1);
        pcs(32'h1000, 8'h0, 1'b1, "R2 pc0 hit");
        pcs(32'h1004, 8'h0, 1'b0, "R2 pc0 miss");
        pc_addr = 32'h1000; step(1'b0, "R2 pc_valid low");
        // R10: status reports the firing, then clears on read
        rd(5'd0, 32'h2, "R10 fired bit");
        rd(5'd0, 32'h0, "R10 cleared by read");

        // R2: fourth comparator, then disabled
        hw(5'd7, 32'h2000);
        hw(5'd1, 32'h9);
        pcs(32'h2000, 8'h0, 1'b1, "R2 pc3 hit");
        hw(5'd1, 32'h1);
        pcs(32'h2000, 8'h0, 1'b0, "R2 pc3 disabled");

        // R6: ASID qualification on comparator 0
        hw(5'd14, 32'h5);
        hw(5'd1, 32'h101);
        pcs(32'h1000, 8'h4, 1'b0, "R6 wrong asid");
        pcs(32'h1000, 8'h5, 1'b1, "R6 right asid");

        // R3/R4: inclusive range on set 0
        hw(5'd8, 32'h100);
        hw(5'd9, 32'h1FF);
        hw(5'd1, 32'h10);
        ops(1, 32'h100, 0, 0, 1'b1, "R3 low bound");
        ops(1, 32'h1FF, 0, 0, 1'b1, "R3 high bound");
        ops(1, 32'h0FF, 0, 0, 1'b0, "R3 below");
        ops(1, 32'h200, 0, 0, 1'b0, "R3 above");
        ops(0, 32'h150, 0, 0, 1'b0, "R4 op_valid low");

        // R3/R6: set 1 with ASID qualifier
        hw(5'd10, 32'h800);
        hw(5'd11, 32'h800);
        hw(5'd15, 32'h7);
        hw(5'd1, 32'h2020);
        ops(1, 32'h800, 0, 8'h7, 1'b1, "R6 range asid match");
        ops(1, 32'h800, 0, 8'h6, 1'b0, "R6 range asid mismatch");

        // R5: masked data comparator
        hw(5'd12, 32'hA5A5_0000);
        hw(5'd13, 32'h0000_FFFF);
        hw(5'd1, 32'h40);
        ops(1, 0, 32'hA5A5_1234, 0, 1'b1, "R5 masked bits ignored");
        ops(1, 0, 32'hA5A4_0000, 0, 1'b0, "R5 unmasked bit differs");
        ops(0, 0, 32'hA5A5_0000, 0, 1'b0, "R4 data needs valid");

        // R8: processor writes honoured unlocked, dropped locked
        cw(5'd5, 32'h4000);
        rd(5'd5, 32'h4000, "R8 cpu write unlocked");
        hw(5'd0, 32'h10);
        cw(5'd5, 32'h5000);
        rd(5'd5, 32'h4000, "R8 cpu write dropped");
        cw(5'd0, 32'h100);
        rd(5'd0, 32'h12, "R8 csr unchanged by cpu");
        hw(5'd5, 32'h6000);
        rd(5'd5, 32'h6000, "R8 host write while locked");

        // R9: collision, host data wins
        hw(5'd0, 32'h0);
        hst_we = 1; hst_idx = 5'd12; hst_wdata = 32'h1111_1111;
        cpu_we = 1; cpu_idx = 5'd12; cpu_wdata = 32'h2222_2222;
        step(1'b0, "R9 collision");
        rd(5'd12, 32'h1111_1111, "R9 host wins");

        // R7: double-level sequencing
        hw(5'd0, 32'h100);
        hw(5'd1, 32'h11);
        ops(1, 32'h150, 0, 0, 1'b0, "R7 op alone does not fire");
        pcs(32'h1000, 8'h0, 1'b0, "R7 level one arms only");
        rd(5'd0, 32'h101, "R10 level-one bit");
        ops(1, 32'h150, 0, 0, 1'b1, "R7 level two fires");
        ops(1, 32'h150, 0, 0, 1'b0, "R7 disarmed after fire");
        // R11: reconfiguration drops the armed state
        pcs(32'h1000, 8'h0, 1'b0, "R7 re-arm");
        hw(5'd1, 32'h11);
        ops(1, 32'h150, 0, 0, 1'b0, "R11 disarmed by write");
        rd(5'd0, 32'h103, "R10 both status bits");
        rd(5'd1, 32'h11, "R12 enable readback");

        repeat (3) @(negedge clk);
        done = 1'b1;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule